// File: doc/BRIEF.md
# Sensor Power-Gating Sequencer for a Variable-Period Buck Controller

This block decides, cycle by cycle, when two sensing circuits of a digitally controlled step-down converter may draw current. The converter's switching period is not fixed, so it is set by a slow period clock whose rising edge starts each conversion phase. At that edge the sequencer switches on both the windowed error ADC and the zero-current detector. Each sensor is then switched off again by its own completion event, not by a timer. For the ADC the event is a strobe that says the error code has been captured. For the detector it is the comparator output falling, which means the inductor current has reached zero.

When the detector trips in discontinuous operation, the block also asks the power train to turn off the low-side switch. It then keeps the detector off until the next period starts. A mode input selects whether this discontinuous behaviour is allowed at all. For each sensor, the block counts how many fast-clock cycles it spent asleep in every period. The count grows with the period length, which gives a direct measure of the power saved at light load. If a period ends before the ADC has reported completion, the ADC is kept on and an overrun flag is raised for the next period.

The ADC path is a three-state machine. ADC_PARKED is the state after reset. The transition *wake* goes from ADC_PARKED or ADC_NAP to ADC_SENSE on a period edge. The transition *capture* goes from ADC_SENSE to ADC_NAP on the done strobe. The transition *overrun* is a period edge in ADC_SENSE with no strobe, and the machine stays in ADC_SENSE. The detector path mirrors this. ZCD_PARKED moves to ZCD_WATCH on *wake*. ZCD_WATCH moves to ZCD_NAP on *trip*, which is a falling comparator output while discontinuous mode is selected. ZCD_NAP returns to ZCD_WATCH on *wake*.

Top module: `sensor_gate_ctrl`

## Requirements
- R1: From reset until the first period edge, adc_en, zcd_en, ls_off_req and adc_overrun are low, both idle counts are zero, and adc_done and comparator falls have no effect.
- R2: A period edge is a cycle in which period_clk is high and was low in the previous cycle. From the next cycle on, adc_en and zcd_en are both high.
- R3: If adc_done is high in a cycle where adc_en is high and there is no period edge, adc_en is low from the next cycle on. It stays low, whatever adc_done does, until the cycle after the next period edge.
- R4: If a period edge arrives while adc_en is high and adc_done is low in that cycle, adc_en stays high. adc_overrun is then high from the next cycle until the cycle after the following period edge, where it is evaluated again in the same way.
- R5: A comparator fall is zc_cmp high in one cycle and low in the next. If dcm_en is high, zcd_en is high and there is no period edge in the cycle of the fall, then from the next cycle zcd_en is low and ls_off_req is high, until the cycle after the next period edge.
- R6: When dcm_en is low, comparator falls are ignored. zcd_en stays high for the whole period and ls_off_req stays low.
- R7: A period edge takes priority over a done strobe or a comparator fall in the same cycle. The sensor stays enabled, and a done strobe in the edge cycle prevents an overrun.
- R8: At each period edge, each idle count is loaded with the number of cycles from the sensor's sleep entry up to and including the edge cycle, or zero if the sensor never slept. The count is held until the next edge, so longer periods with the same sense time give proportionally larger counts.
- R9: An idle count that would exceed the largest value of its IDLE_W bits saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_clk | input | 1 | Switching-period clock, synchronous to clk; its rising edge starts a period |
| adc_done | input | 1 | ADC sampling-complete strobe |
| zc_cmp | input | 1 | Zero-current comparator output; its fall marks inductor current at zero |
| dcm_en | input | 1 | 1: discontinuous operation allowed (detector may sleep); 0: detector held on |
| adc_en | output | 1 | Enable of the windowed error ADC |
| zcd_en | output | 1 | Enable of the zero-current detector |
| ls_off_req | output | 1 | Request to turn off the low-side switch |
| adc_overrun | output | 1 | Previous period ended before the ADC completed |
| adc_idle_cnt | output | IDLE_W | ADC sleep cycles measured over the last period |
| zcd_idle_cnt | output | IDLE_W | Detector sleep cycles measured over the last period |

## Verification
The hardest situations to reach are the collisions, where a period edge lands in the same cycle as the done strobe or as the comparator fall. Both events are produced by separate stimulus in the bench, so they must be lined up on purpose. The stimulus task places the strobe or the fall at a chosen offset inside a period, including offset zero, which coincides with the edge. It also chains a period with no strobe into one with an edge-cycle strobe, so an overrun is followed by a collision. Long periods measured with a narrow count width drive the idle counters into saturation.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

    typedef enum logic [1:0] {
        ADC_PARKED = 2'd0,
        ADC_SENSE  = 2'd1,
        ADC_NAP    = 2'd2
    } adc_state_e;

    typedef enum logic [1:0] {
        ZCD_PARKED = 2'd0,
        ZCD_WATCH  = 2'd1,
        ZCD_NAP    = 2'd2
    } zcd_state_e;

    localparam int unsigned SENSOR_CNT = 2;
    localparam int unsigned SENSOR_ADC = 0;
    localparam int unsigned SENSOR_ZCD = 1;

endpackage

// File: rtl/sgc_edge_det.sv
module sgc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic period_clk,
    input  logic zc_cmp,
    output logic period_edge,
    output logic zc_fall
);

    logic period_prev_q;
    logic zc_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_prev_q <= 1'b0;
            zc_prev_q     <= 1'b0;
        end else begin
            period_prev_q <= period_clk;
            zc_prev_q     <= zc_cmp;
        end
    end

    always_comb begin
        period_edge = period_clk && !period_prev_q;
        zc_fall     = zc_prev_q && !zc_cmp;
    end

endmodule

// File: rtl/sgc_adc_fsm.sv
module sgc_adc_fsm
    import sgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic period_edge,
    input  logic adc_done,
    output logic adc_en,
    output logic adc_asleep,
    output logic adc_overrun
);

    adc_state_e state_q;
    adc_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ADC_PARKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ADC_PARKED: if (period_edge) state_d = ADC_SENSE;
            ADC_SENSE: begin
                if (period_edge)   state_d = ADC_SENSE;
                else if (adc_done) state_d = ADC_NAP;
            end
            ADC_NAP:    if (period_edge) state_d = ADC_SENSE;
            default:    state_d = ADC_PARKED;
        endcase
    end

    always_comb begin
        adc_en     = 1'b0;
        adc_asleep = 1'b0;
        unique case (state_q)
            ADC_PARKED: ;
            ADC_SENSE:  adc_en     = 1'b1;
            ADC_NAP:    adc_asleep = 1'b1;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_overrun <= 1'b0;
        end else if (period_edge) begin
            adc_overrun <= (state_q == ADC_SENSE) && !adc_done;
        end
    end

    a_r2_adc_wake: assert property (@(posedge clk) disable iff (!rst_n)
        period_edge |=> adc_en);

    a_r3_adc_nap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_en && !period_edge) |=> !adc_en);

    a_r4_adc_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_en && period_edge && !adc_done) |=> (adc_en && adc_overrun));

    a_r7_adc_edge_done: assert property (@(posedge clk) disable iff (!rst_n)
        (period_edge && adc_done) |=> !adc_overrun);

endmodule

// File: rtl/sgc_zcd_fsm.sv
module sgc_zcd_fsm
    import sgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic period_edge,
    input  logic zc_fall,
    input  logic dcm_en,
    output logic zcd_en,
    output logic zcd_asleep,
    output logic ls_off_req
);

    zcd_state_e state_q;
    zcd_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ZCD_PARKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ZCD_PARKED: if (period_edge) state_d = ZCD_WATCH;
            ZCD_WATCH: begin
                if (period_edge)            state_d = ZCD_WATCH;
                else if (dcm_en && zc_fall) state_d = ZCD_NAP;
            end
            ZCD_NAP:    if (period_edge) state_d = ZCD_WATCH;
            default:    state_d = ZCD_PARKED;
        endcase
    end

    always_comb begin
        zcd_en     = 1'b0;
        zcd_asleep = 1'b0;
        ls_off_req = 1'b0;
        unique case (state_q)
            ZCD_PARKED: ;
            ZCD_WATCH:  zcd_en = 1'b1;
            ZCD_NAP: begin
                zcd_asleep = 1'b1;
                ls_off_req = 1'b1;
            end
            default:    ;
        endcase
    end

    a_r5_zcd_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (zcd_en && dcm_en && zc_fall && !period_edge) |=> (!zcd_en && ls_off_req));

    a_r6_zcd_ccm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (zcd_en && !dcm_en) |=> (zcd_en && !ls_off_req));

    a_r7_zcd_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        period_edge |=> (zcd_en && !ls_off_req));

endmodule

// File: rtl/sgc_idle_meter.sv
module sgc_idle_meter #(
    parameter int unsigned IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_edge,
    input  logic              asleep,
    output logic [IDLE_W-1:0] idle_cnt
);

    localparam logic [IDLE_W-1:0] CNT_TOP = '1;

    logic [IDLE_W-1:0] run_q;
    logic [IDLE_W-1:0] run_inc;

    always_comb begin
        run_inc = (run_q == CNT_TOP) ? run_q : run_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= '0;
            idle_cnt <= '0;
        end else if (period_edge) begin
            idle_cnt <= asleep ? run_inc : '0;
            run_q    <= '0;
        end else if (asleep) begin
            run_q <= run_inc;
        end
    end

    a_r8_idle_zero_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (period_edge && !asleep) |=> (idle_cnt == '0));

    a_r8_idle_held: assert property (@(posedge clk) disable iff (!rst_n)
        !period_edge |=> $stable(idle_cnt));

endmodule

// File: rtl/sensor_gate_ctrl.sv
module sensor_gate_ctrl
    import sgc_pkg::*;
#(
    parameter int unsigned IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_clk,
    input  logic              adc_done,
    input  logic              zc_cmp,
    input  logic              dcm_en,
    output logic              adc_en,
    output logic              zcd_en,
    output logic              ls_off_req,
    output logic              adc_overrun,
    output logic [IDLE_W-1:0] adc_idle_cnt,
    output logic [IDLE_W-1:0] zcd_idle_cnt
);

    logic                  period_edge;
    logic                  zc_fall;
    logic [SENSOR_CNT-1:0] asleep_vec;
    logic [IDLE_W-1:0]     idle_arr [SENSOR_CNT];

    sgc_edge_det u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_clk  (period_clk),
        .zc_cmp      (zc_cmp),
        .period_edge (period_edge),
        .zc_fall     (zc_fall)
    );

    sgc_adc_fsm u_adc (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_edge (period_edge),
        .adc_done    (adc_done),
        .adc_en      (adc_en),
        .adc_asleep  (asleep_vec[SENSOR_ADC]),
        .adc_overrun (adc_overrun)
    );

    sgc_zcd_fsm u_zcd (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_edge (period_edge),
        .zc_fall     (zc_fall),
        .dcm_en      (dcm_en),
        .zcd_en      (zcd_en),
        .zcd_asleep  (asleep_vec[SENSOR_ZCD]),
        .ls_off_req  (ls_off_req)
    );

    for (genvar g = 0; g < SENSOR_CNT; g++) begin : g_meter
        sgc_idle_meter #(.IDLE_W(IDLE_W)) u_meter (
            .clk         (clk),
            .rst_n       (rst_n),
            .period_edge (period_edge),
            .asleep      (asleep_vec[g]),
            .idle_cnt    (idle_arr[g])
        );
    end

    assign adc_idle_cnt = idle_arr[SENSOR_ADC];
    assign zcd_idle_cnt = idle_arr[SENSOR_ZCD];

    a_r1_parked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_en && !adc_overrun && !$past(period_edge)) |=> !adc_overrun);

endmodule

// File: tb/sensor_gate_ctrl_tb.sv
module sensor_gate_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IDLE_W     = 6;
    localparam int CNT_TOP    = (1 << IDLE_W) - 1;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              period_clk = 1'b0;
    logic              adc_done = 1'b0;
    logic              zc_cmp = 1'b0;
    logic              dcm_en = 1'b1;
    logic              adc_en;
    logic              zcd_en;
    logic              ls_off_req;
    logic              adc_overrun;
    logic [IDLE_W-1:0] adc_idle_cnt;
    logic [IDLE_W-1:0] zcd_idle_cnt;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // behavioural reference state
    bit m_prd_prev = 0, m_zc_prev = 0;
    bit m_a_run = 0, m_a_on = 0, m_ovr = 0;
    bit m_z_run = 0, m_z_on = 0;
    int m_a_cnt = 0, m_z_cnt = 0, m_a_idle = 0, m_z_idle = 0;

    sensor_gate_ctrl #(.IDLE_W(IDLE_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_clk   (period_clk),
        .adc_done     (adc_done),
        .zc_cmp       (zc_cmp),
        .dcm_en       (dcm_en),
        .adc_en       (adc_en),
        .zcd_en       (zcd_en),
        .ls_off_req   (ls_off_req),
        .adc_overrun  (adc_overrun),
        .adc_idle_cnt (adc_idle_cnt),
        .zcd_idle_cnt (zcd_idle_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int sat_inc(int v);
        return (v >= CNT_TOP) ? CNT_TOP : v + 1;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_prd_prev = 0; m_zc_prev = 0;
            m_a_run = 0; m_a_on = 0; m_ovr = 0;
            m_z_run = 0; m_z_on = 0;
            m_a_cnt = 0; m_z_cnt = 0; m_a_idle = 0; m_z_idle = 0;
        end else begin
            bit pe, zf;
            pe = period_clk && !m_prd_prev;
            zf = m_zc_prev && !zc_cmp;
            if (pe) begin
                if (m_a_run) m_ovr = m_a_on && !adc_done;
                m_a_idle = (m_a_run && !m_a_on) ? sat_inc(m_a_cnt) : 0;
                m_z_idle = (m_z_run && !m_z_on) ? sat_inc(m_z_cnt) : 0;
                m_a_cnt = 0; m_z_cnt = 0;
                m_a_run = 1; m_a_on = 1;
                m_z_run = 1; m_z_on = 1;
            end else begin
                if (m_a_run && m_a_on && adc_done) m_a_on = 0;
                else if (m_a_run && !m_a_on) m_a_cnt = sat_inc(m_a_cnt);
                if (m_z_run && m_z_on && dcm_en && zf) m_z_on = 0;
                else if (m_z_run && !m_z_on) m_z_cnt = sat_inc(m_z_cnt);
            end
            m_prd_prev = period_clk;
            m_zc_prev  = zc_cmp;
        end
    end

    task automatic chk(string req, int act, int exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
        end
    endtask

    // compare every output on every falling edge, away from the active edge
    always @(negedge clk) begin
        vectors++;
        chk("R1/R2/R3 adc_en",        adc_en,       m_a_on);
        chk("R2/R5/R6 zcd_en",        zcd_en,       m_z_on);
        chk("R5/R6 ls_off_req",       ls_off_req,   m_z_run && !m_z_on);
        chk("R4/R7 adc_overrun",      adc_overrun,  m_ovr);
        chk("R8/R9 adc_idle_cnt",     adc_idle_cnt, m_a_idle);
        chk("R8/R9 zcd_idle_cnt",     zcd_idle_cnt, m_z_idle);
    end

    // one switching period: edge at index 0, done strobe and comparator fall at given offsets (-1: none)
    task automatic run_period(int len, int done_at, int fall_at);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            period_clk = (i < 2);
            adc_done   = (i == done_at);
            if (fall_at == 0)      zc_cmp = 1'b0;
            else if (i == 0)       zc_cmp = zc_cmp;
            else if (fall_at < 0)  zc_cmp = 1'b1;
            else                   zc_cmp = (i < fall_at);
        end
    endtask

    initial begin
        fork
            begin
                repeat (WATCHDOG) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
            end
            begin
                // R1: reset, then stray strobes and falls before any edge
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk); adc_done = 1'b1; zc_cmp = 1'b1;
                @(negedge clk); adc_done = 1'b0; zc_cmp = 1'b0;
                repeat (4) @(negedge clk);
                // R2 R3 R5 R8: discontinuous periods of growing length
                dcm_en = 1'b1;
                run_period(20, 3, 10);
                run_period(40, 3, 10);
                run_period(50, 5, 30);
                // R4: ADC never completes, then R7 done coincident with edge
                run_period(25, -1, 8);
                run_period(25, 0, 8);
                run_period(25, 4, -1);
                // R7: comparator fall coincident with edge
                run_period(25, 4, 0);
                run_period(25, 4, 6);
                // R6: continuous mode ignores falls
                dcm_en = 1'b0;
                run_period(30, 6, 12);
                run_period(30, 6, 20);
                dcm_en = 1'b1;
                // R9: long periods saturate the narrow counters
                run_period(100, 2, 5);
                run_period(90, 2, 5);
                run_period(20, 2, 5);
                repeat (5) @(negedge clk);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule